// File: doc/BRIEF.md
# Write-Through Store Queue with Read-Miss Bypass

This block sits between a write-through cache and a slower memory. Each store that the cache sees is also pushed, as an address/data pair, into a small in-order queue. The memory side drains the queue through a single valid/ready request port, oldest store first. The same request port also carries cache read misses, so the block decides, cycle by cycle, whether the port carries a queued write or the pending read.

When a read miss is presented, its block address is compared in parallel with the block address of every resident entry. With no match, the read takes the memory port ahead of the queued stores, so the miss penalty does not include the queue drain time. With a match, the read is held back until the matching stores, and every store older than them, have been accepted by memory. This guarantees that the read never fetches stale data. A parameter selects a simpler variant in which every read waits for the queue to become empty.

A request that memory has not yet accepted stays on the port unchanged until it is taken. A newly arrived read therefore never displaces a write that is already being offered. The occupancy count, full flag and empty flag are provided as outputs.

Top module: `write_buffer_rp`

## Requirements
- R1: After reset the queue is empty: `buf_empty`=1, `buf_full`=0, `buf_count`=0, and `mem_req_valid`=0 while no read is presented.
- R2: Queued stores leave through the memory port in the order they were accepted, with `mem_req_write`=1 and their address and data unchanged.
- R3: With DEPTH (default 4) entries resident, `buf_full`=1 and `st_ready`=0, and a store offered in that state is not taken. The count never exceeds DEPTH.
- R4: A read whose block address (address bits above BLK_OFF, default 4, i.e. 16-byte blocks) matches no resident entry is offered on the memory port (`mem_req_write`=0, `mem_req_addr`=read address) ahead of the stores still queued.
- R5: A read whose block matches any resident entry, including a store to a different word of that block, is not offered until the last matching entry has been accepted. The older writes go first, in order.
- R6: `buf_count` rises by one for each accepted store, falls by one for each write accepted by memory, and `buf_empty` is 1 exactly when the count is zero.
- R7: `rd_ready` is 1 only in a cycle where memory accepts the read request that carries `rd_addr`.
- R8: Once the memory port offers a request that is not accepted, the next cycle offers the same request (valid, kind and address unchanged), even if a new read arrives meanwhile.
- R9: With BYPASS=0, a read is offered only when the queue is empty, whatever the addresses.
- R10: Parameters are checked at elaboration: DEPTH must be a power of two of at least 2, and BLK_OFF must be below the address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | A store is presented |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store accepted this cycle (low when full) |
| rd_valid | input | 1 | A read miss is presented; held until `rd_ready` |
| rd_addr | input | AW | Read miss address |
| rd_ready | output | 1 | Read miss accepted by memory this cycle |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write from queue head, 0 = read miss |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Write data (zero for reads) |
| mem_req_ready | input | 1 | Memory accepts the request |
| buf_full | output | 1 | All entries occupied |
| buf_empty | output | 1 | No entry occupied |
| buf_count | output | $clog2(DEPTH)+1 | Number of occupied entries |

## Verification
The hardest case to reach is a read whose block hits an entry in the middle of the queue, so that some writes must go before it and others after it. A second hard case is a read that arrives while an earlier write is stuck on a stalled memory port. The stimulus holds memory not-ready while it fills the queue with stores to distinct blocks. It then presents the read, with the matching store placed second and written to another word of the same block, and finally releases memory for one acceptance per cycle. The grant sequence is then checked cycle by cycle. A second instance built with bypass disabled receives the same kind of traffic, to show that the read waits for the whole queue to drain.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   // state of the memory-port hold: which request kind is parked on the port
   typedef enum logic [1:0] {
      HOLD_NONE = 2'd0,
      HOLD_WR   = 2'd1,
      HOLD_RD   = 2'd2
   } hold_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int DEPTH   = 4,
   parameter int BLK_OFF = 4,
   localparam int PW     = $clog2(DEPTH),
   localparam int CW     = PW + 1,
   localparam int BW     = AW - BLK_OFF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [AW-1:0]               push_addr,
   input  logic [DW-1:0]               push_data,
   input  logic                        pop,
   output logic [AW-1:0]               head_addr,
   output logic [DW-1:0]               head_data,
   output logic [DEPTH-1:0][BW-1:0]    ent_blk,
   output logic [DEPTH-1:0]            ent_vld,
   output logic [CW-1:0]               count,
   output logic                        full,
   output logic                        empty
);
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;
   logic [DEPTH-1:0]         vld_q;
   logic [PW-1:0]            wr_ptr;
   logic [PW-1:0]            rd_ptr;
   logic [CW-1:0]            cnt_q;

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
         vld_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         for (int i = 0; i < DEPTH; i++) begin
            if (push && (wr_ptr == PW'(i)))      vld_q[i] <= 1'b1;
            else if (pop && (rd_ptr == PW'(i)))  vld_q[i] <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_blk
      assign ent_blk[g] = addr_q[g][AW-1:BLK_OFF];
   end

   assign ent_vld   = vld_q;
   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];
   assign count     = cnt_q;
   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int BW    = 28,
   parameter int DEPTH = 4
) (
   input  logic [BW-1:0]            probe_blk,
   input  logic [DEPTH-1:0][BW-1:0] ent_blk,
   input  logic [DEPTH-1:0]         ent_vld,
   output logic                     hit
);
   logic [DEPTH-1:0] hit_vec;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = ent_vld[g] && (ent_blk[g] == probe_blk);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
   import wbuf_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter bit BYPASS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_addr,
   input  logic          conflict,
   input  logic          empty,
   input  logic [AW-1:0] head_addr,
   input  logic [DW-1:0] head_data,
   input  logic          mem_req_ready,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_data,
   output logic          rd_ready,
   output logic          pop
);
   hold_t hold_q;
   logic  rd_ok;
   logic  take_rd;
   logic  take_wr;

   // variant: bypass on no address match, or wait for an empty queue
   if (BYPASS) begin : g_bypass
      assign rd_ok = rd_valid && !conflict;
   end else begin : g_drain_first
      assign rd_ok = rd_valid && empty;
   end

   always_comb begin
      take_rd = 1'b0;
      take_wr = 1'b0;
      case (hold_q)
         HOLD_WR: take_wr = 1'b1;
         HOLD_RD: take_rd = rd_valid;
         default: begin
            if (rd_ok)        take_rd = 1'b1;
            else if (!empty)  take_wr = 1'b1;
         end
      endcase
   end

   assign mem_req_valid = take_rd || take_wr;
   assign mem_req_write = take_wr;
   assign mem_req_addr  = take_wr ? head_addr : rd_addr;
   assign mem_req_data  = take_wr ? head_data : '0;
   assign rd_ready      = take_rd && mem_req_ready;
   assign pop           = take_wr && mem_req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= HOLD_NONE;
      end else if (mem_req_valid && !mem_req_ready) begin
         hold_q <= take_wr ? HOLD_WR : HOLD_RD;
      end else begin
         hold_q <= HOLD_NONE;
      end
   end
endmodule

// File: rtl/write_buffer_rp.sv
module write_buffer_rp #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int DEPTH   = 4,
   parameter int BLK_OFF = 4,
   parameter bit BYPASS  = 1'b1,
   localparam int PW     = $clog2(DEPTH),
   localparam int CW     = PW + 1,
   localparam int BW     = AW - BLK_OFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   output logic          st_ready,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_ready,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_data,
   input  logic          mem_req_ready,
   output logic          buf_full,
   output logic          buf_empty,
   output logic [CW-1:0] buf_count
);
   // R10: parameter legality
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("write_buffer_rp: DEPTH must be a power of two, at least 2");
   end
   if (BLK_OFF < 0 || BLK_OFF >= AW) begin : g_bad_off
      $error("write_buffer_rp: BLK_OFF must lie below AW");
   end

   logic                     push;
   logic                     pop;
   logic                     conflict;
   logic [AW-1:0]            head_addr;
   logic [DW-1:0]            head_data;
   logic [DEPTH-1:0][BW-1:0] ent_blk;
   logic [DEPTH-1:0]         ent_vld;

   assign st_ready = !buf_full;
   assign push     = st_valid && st_ready;

   wbuf_store #(
      .AW(AW), .DW(DW), .DEPTH(DEPTH), .BLK_OFF(BLK_OFF)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .head_addr (head_addr),
      .head_data (head_data),
      .ent_blk   (ent_blk),
      .ent_vld   (ent_vld),
      .count     (buf_count),
      .full      (buf_full),
      .empty     (buf_empty)
   );

   wbuf_match #(
      .BW(BW), .DEPTH(DEPTH)
   ) u_match (
      .probe_blk (rd_addr[AW-1:BLK_OFF]),
      .ent_blk   (ent_blk),
      .ent_vld   (ent_vld),
      .hit       (conflict)
   );

   wbuf_arb #(
      .AW(AW), .DW(DW), .BYPASS(BYPASS)
   ) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_valid      (rd_valid),
      .rd_addr       (rd_addr),
      .conflict      (conflict),
      .empty         (buf_empty),
      .head_addr     (head_addr),
      .head_data     (head_data),
      .mem_req_ready (mem_req_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_data  (mem_req_data),
      .rd_ready      (rd_ready),
      .pop           (pop)
   );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
   parameter int AW     = 32,
   parameter int DEPTH  = 4,
   parameter bit BYPASS = 1'b1,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_valid,
   input logic          st_ready,
   input logic [AW-1:0] rd_addr,
   input logic          rd_ready,
   input logic          mem_req_valid,
   input logic          mem_req_write,
   input logic [AW-1:0] mem_req_addr,
   input logic          mem_req_ready,
   input logic          buf_full,
   input logic          buf_empty,
   input logic [CW-1:0] buf_count
);
   logic in_w, out_w;
   assign in_w  = st_valid && st_ready;
   assign out_w = mem_req_valid && mem_req_ready && mem_req_write;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_count <= CW'(DEPTH)) && (buf_full -> !st_ready));

   p_count_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> buf_count == $past(buf_count) + CW'($past(in_w)) - CW'($past(out_w)));

   p_no_write_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty |-> !(mem_req_valid && mem_req_write));

   p_rd_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> (mem_req_valid && mem_req_ready && !mem_req_write && mem_req_addr == rd_addr));

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready && mem_req_write) |=>
         (mem_req_valid && mem_req_write && $stable(mem_req_addr)));

   p_drain_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!BYPASS && rd_ready) |-> buf_empty);
endmodule

bind write_buffer_rp wbuf_chk #(.AW(AW), .DEPTH(DEPTH), .BYPASS(BYPASS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .st_valid      (st_valid),
   .st_ready      (st_ready),
   .rd_addr       (rd_addr),
   .rd_ready      (rd_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .buf_full      (buf_full),
   .buf_empty     (buf_empty),
   .buf_count     (buf_count)
);

// File: tb/sim_write_buffer_rp.sv
module sim_write_buffer_rp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   int          total = 0;
   int          bad = 0;

   // u0: bypass variant
   logic        st_valid = 0, rd_valid = 0, mem_ready = 0;
   logic [31:0] st_addr = 0, st_data = 0, rd_addr = 0;
   logic        st_ready, rd_ready, mq_valid, mq_write, full, empty;
   logic [31:0] mq_addr, mq_data;
   logic [2:0]  count;

   // u1: drain-first variant
   logic        b_st_valid = 0, b_rd_valid = 0, b_mem_ready = 0;
   logic [31:0] b_st_addr = 0, b_st_data = 0, b_rd_addr = 0;
   logic        b_st_ready, b_rd_ready, b_mq_valid, b_mq_write, b_full, b_empty;
   logic [31:0] b_mq_addr, b_mq_data;
   logic [2:0]  b_count;

   always #5 clk = ~clk;

   write_buffer_rp u0 (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .mem_req_valid(mq_valid), .mem_req_write(mq_write), .mem_req_addr(mq_addr),
      .mem_req_data(mq_data), .mem_req_ready(mem_ready),
      .buf_full(full), .buf_empty(empty), .buf_count(count)
   );

   write_buffer_rp #(.BYPASS(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .st_valid(b_st_valid), .st_addr(b_st_addr), .st_data(b_st_data), .st_ready(b_st_ready),
      .rd_valid(b_rd_valid), .rd_addr(b_rd_addr), .rd_ready(b_rd_ready),
      .mem_req_valid(b_mq_valid), .mem_req_write(b_mq_write), .mem_req_addr(b_mq_addr),
      .mem_req_data(b_mq_data), .mem_req_ready(b_mem_ready),
      .buf_full(b_full), .buf_empty(b_empty), .buf_count(b_count)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // expect a write from the queue head on the u0 port
   task automatic see_wr(input string req, input logic [31:0] a, input logic [31:0] d);
      chk(req, "valid", 32'(mq_valid), 1);
      chk(req, "write", 32'(mq_write), 1);
      chk(req, "addr", mq_addr, a);
      chk(req, "data", mq_data, d);
   endtask

   task automatic push0(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); st_valid = 1; st_addr = a; st_data = d;
      @(negedge clk); st_valid = 0;
   endtask

   task automatic push1(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); b_st_valid = 1; b_st_addr = a; b_st_data = d;
      @(negedge clk); b_st_valid = 0;
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "empty", 32'(empty), 1);
      chk("R1", "full", 32'(full), 0);
      chk("R1", "count", 32'(count), 0);
      chk("R1", "mem valid", 32'(mq_valid), 0);
   endtask

   task automatic t_fill_drain();
      mem_ready = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         st_valid = 1; st_addr = 32'h1000 + 32'(i) * 32'h10; st_data = 32'hA0 + 32'(i);
         #1;
         chk("R6", "count while filling", 32'(count), 32'(i));
         chk("R3", "st_ready below full", 32'(st_ready), 1);
      end
      @(negedge clk);
      st_addr = 32'h9990; st_data = 32'hEE;
      #1;
      chk("R3", "full", 32'(full), 1);
      chk("R3", "st_ready at full", 32'(st_ready), 0);
      chk("R6", "count at full", 32'(count), 4);
      @(negedge clk); st_valid = 0; #1;
      chk("R3", "count after refused store", 32'(count), 4);
      mem_ready = 1;
      for (int i = 0; i < 4; i++) begin
         #1;
         see_wr("R2", 32'h1000 + 32'(i) * 32'h10, 32'hA0 + 32'(i));
         chk("R6", "count while draining", 32'(count), 32'(4 - i));
         @(negedge clk);
      end
      #1;
      chk("R3", "refused store not queued", 32'(empty), 1);
      chk("R6", "count drained", 32'(count), 0);
      chk("R2", "idle port", 32'(mq_valid), 0);
      mem_ready = 0;
   endtask

   task automatic t_read_wait();
      @(negedge clk); rd_valid = 1; rd_addr = 32'h700; #1;
      chk("R7", "read offered", 32'(mq_valid & ~mq_write), 1);
      chk("R7", "no ready while stalled", 32'(rd_ready), 0);
      @(negedge clk); #1;
      chk("R8", "read held addr", mq_addr, 32'h700);
      chk("R8", "read held valid", 32'(mq_valid), 1);
      mem_ready = 1; #1;
      chk("R7", "ready on accept", 32'(rd_ready), 1);
      @(negedge clk); rd_valid = 0; mem_ready = 0; #1;
      chk("R7", "port idle after read", 32'(mq_valid), 0);
   endtask

   task automatic t_bypass();
      push0(32'h100, 32'h1); push0(32'h200, 32'h2); push0(32'h300, 32'h3);
      rd_valid = 1; rd_addr = 32'h500; #1;
      see_wr("R8", 32'h100, 32'h1);
      chk("R8", "parked write keeps port", 32'(rd_ready), 0);
      @(negedge clk); mem_ready = 1; #1;
      see_wr("R8", 32'h100, 32'h1);
      @(negedge clk); #1;
      chk("R4", "read kind", 32'(mq_write), 0);
      chk("R4", "read addr", mq_addr, 32'h500);
      chk("R4", "read accepted", 32'(rd_ready), 1);
      chk("R4", "writes still queued", 32'(count), 2);
      @(negedge clk); rd_valid = 0; #1;
      see_wr("R4", 32'h200, 32'h2);
      @(negedge clk); #1;
      see_wr("R4", 32'h300, 32'h3);
      @(negedge clk); #1;
      chk("R4", "empty after", 32'(empty), 1);
      mem_ready = 0;
   endtask

   task automatic t_conflict();
      push0(32'h100, 32'h11); push0(32'h204, 32'h22); push0(32'h300, 32'h33);
      rd_valid = 1; rd_addr = 32'h208; mem_ready = 1; #1;
      see_wr("R5", 32'h100, 32'h11);
      chk("R5", "read blocked 1", 32'(rd_ready), 0);
      @(negedge clk); #1;
      see_wr("R5", 32'h204, 32'h22);
      chk("R5", "read blocked by same block", 32'(rd_ready), 0);
      @(negedge clk); #1;
      chk("R5", "read kind", 32'(mq_write), 0);
      chk("R5", "read addr", mq_addr, 32'h208);
      chk("R5", "read accepted", 32'(rd_ready), 1);
      chk("R5", "younger write left", 32'(count), 1);
      @(negedge clk); rd_valid = 0; #1;
      see_wr("R5", 32'h300, 32'h33);
      @(negedge clk); #1;
      chk("R5", "empty after", 32'(empty), 1);
      mem_ready = 0;
   endtask

   task automatic t_fallback();
      push1(32'h100, 32'h5); push1(32'h200, 32'h6);
      b_rd_valid = 1; b_rd_addr = 32'h500; b_mem_ready = 1; #1;
      chk("R9", "first write", b_mq_addr, 32'h100);
      chk("R9", "read waits 1", 32'(b_rd_ready), 0);
      @(negedge clk); #1;
      chk("R9", "second write", b_mq_addr, 32'h200);
      chk("R9", "read waits 2", 32'(b_rd_ready), 0);
      @(negedge clk); #1;
      chk("R9", "read after drain", 32'(b_rd_ready), 1);
      chk("R9", "read addr", b_mq_addr, 32'h500);
      @(negedge clk); b_rd_valid = 0; b_mem_ready = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_fill_drain();
      t_read_wait();
      t_bypass();
      t_conflict();
      t_fallback();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule